// File: doc/BRIEF.md
# Sample FIFO Write Port with Bus-Width Packing

This block sits between a 32-bit register bus and a small FIFO of 16-bit sample entries. Software may write samples with 8-bit, 16-bit or 32-bit stores. The block checks each store against alignment and occupancy rules and drops, without any response, a store that breaks them. A 16-bit store fills one entry. A 32-bit store fills two entries. Two byte stores, which may come in either order, together fill one entry.

A consumer on the read side removes the oldest entry with a pop strobe and sees that entry on the head output at all times. A separate read port returns any storage slot by its absolute index, and that read has no effect on the FIFO pointers. Occupancy is tracked with an entry counter, which drives the full and empty flags.

Top module: `sample_fifo_wport`

## Requirements
- R1: After reset the FIFO holds no entries: `fifoCount` is 0, `fifoEmpty` is 1 and `fifoFull` is 0.
- R2: A store with `wrSize`=1 (16-bit) and `wrAddr[1]`=0 is accepted when the FIFO is not full. It places `wrData[15:0]` in one entry and raises the count by 1 at the next clock edge.
- R3: An 8-bit (`wrSize`=0) or 16-bit store with `wrAddr[1]`=1 is dropped. It changes neither the count nor the stored data. A store with the reserved `wrSize`=3 is dropped in the same way.
- R4: A 32-bit store (`wrSize`=2) is dropped when the write pointer is odd.
- R5: An accepted 32-bit store puts `wrData[15:0]` in the entry at the write pointer and `wrData[31:16]` in the entry after it. It raises the count by 2.
- R6: When the count equals the depth, `fifoFull` is 1 and every store of every size is dropped.
- R7: A 32-bit store is dropped when exactly one free slot remains.
- R8: For an 8-bit store with `wrAddr[1]`=0, `wrAddr[0]`=0 takes the low byte from `wrData[7:0]` and `wrAddr[0]`=1 takes the high byte from `wrData[15:8]`. The entry is committed, and the count raised by 1, only once both lanes have been written, in either order. An accepted 16-bit or 32-bit store discards a half-written entry.
- R9: `rdData` returns the storage slot whose absolute index is `rdAddr`, and changes neither the count nor the head.
- R10: When `popEn` is asserted and the FIFO is not empty, the oldest entry is removed and the count falls by 1. A pop on an empty FIFO is ignored. An accepted one-entry push in the same cycle as a pop leaves the count unchanged.
- R11: Both pointers wrap modulo the depth, so entries come out in the order they were written across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Bus write strobe, one store per cycle |
| wrAddr | input | 2 | Byte offset of the store within the 32-bit data word |
| wrSize | input | 2 | Store size: 0 byte, 1 half-word, 2 word, 3 reserved |
| wrData | input | 32 | Store data, byte lanes placed little-endian |
| popEn | input | 1 | Removes the head entry |
| rdAddr | input | IDX_W | Absolute slot index for a storage read |
| rdData | output | 16 | Contents of slot `rdAddr` |
| headData | output | 16 | Oldest entry in the FIFO |
| fifoCount | output | CNT_W | Number of entries held |
| fifoFull | output | 1 | Count equals depth |
| fifoEmpty | output | 1 | Count is zero |

## Verification
The packing path is exercised with three kinds of traffic:
- half-word stores, which show that one entry is filled per store;
- word stores, which show the low-then-high entry order;
- byte pairs sent high-lane first, which show that a single lane does not advance the FIFO and that assembly does not depend on order.

Each drop rule is tested on its own by reaching the exact state that triggers it:
- a misaligned offset with the FIFO otherwise able to accept;
- an odd write pointer with plenty of room;
- fifteen entries with an even pointer;
- a full FIFO with each store size.

A scoreboard compares every popped head against the modelled order, through a pointer wrap, so that lost entries, extra entries and swapped halves can each be told apart.

// File: rtl/sfw_pkg.sv
package sfw_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } sfw_size_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       ldLo;    // write low byte of entry at write pointer
    logic       ldHi;    // write high byte of entry at write pointer
    logic       ldPair;  // write two entries from a 32-bit store
    logic [1:0] adv;     // write pointer advance: 0, 1 or 2
    logic       pop;     // advance read pointer
  } sfw_strb_t;

endpackage

// File: rtl/sfw_ctrl.sv
module sfw_ctrl
  import sfw_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [1:0]       wrSize,
  input  logic             popEn,
  input  logic             wrPtrOdd,
  output sfw_strb_t        strb,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  localparam logic [CNT_W-1:0] CntMax  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CntTwo  = CNT_W'(DEPTH - 2);

  sfw_size_e  sizeSel;
  logic [1:0] pendQ, pendD;
  logic [1:0] laneBit;
  logic       hasRoom, twoRoom, accept, commit;
  logic [CNT_W-1:0] countD;

  assign sizeSel = sfw_size_e'(wrSize);
  assign full    = (count == CntMax);
  assign empty   = (count == '0);
  assign hasRoom = !full;
  assign twoRoom = (count <= CntTwo);
  assign laneBit = wrAddr[0] ? 2'b10 : 2'b01;

  always_comb begin
    strb   = '0;
    accept = 1'b0;
    commit = 1'b0;
    pendD  = pendQ;
    if (wrEn) begin
      unique case (sizeSel)
        SZ_BYTE: begin
          accept = !wrAddr[1] && hasRoom;
          if (accept) begin
            strb.ldLo = !wrAddr[0];
            strb.ldHi = wrAddr[0];
            commit    = ((pendQ | laneBit) == 2'b11);
            strb.adv  = commit ? 2'd1 : 2'd0;
            pendD     = commit ? 2'b00 : (pendQ | laneBit);
          end
        end
        SZ_HALF: begin
          accept = !wrAddr[1] && hasRoom;
          if (accept) begin
            strb.ldLo = 1'b1;
            strb.ldHi = 1'b1;
            strb.adv  = 2'd1;
            pendD     = 2'b00;
          end
        end
        SZ_WORD: begin
          accept = !wrPtrOdd && twoRoom;
          if (accept) begin
            strb.ldPair = 1'b1;
            strb.adv    = 2'd2;
            pendD       = 2'b00;
          end
        end
        default: accept = 1'b0;
      endcase
    end
    strb.pop = popEn && !empty;
    countD   = count + CNT_W'(strb.adv) - CNT_W'(strb.pop);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      pendQ <= '0;
    end else begin
      count <= countD;
      pendQ <= pendD;
    end
  end

  // R6: a store into a full FIFO with no pop leaves the count alone
  a_r6_full_drop: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && full && !popEn) |=> $stable(count));

  // R3: misaligned narrow stores are dropped
  a_r3_misalign_drop: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSize != 2'd2 && wrAddr[1] && !popEn) |=> $stable(count));

  // R7: a word store with one free slot is dropped
  a_r7_one_slot_drop: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSize == 2'd2 && count == CNT_W'(DEPTH - 1) && !popEn) |=> $stable(count));

  // R10: popping an empty FIFO with no store keeps it empty
  a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && empty && !wrEn) |=> empty);

  // R6: the count never passes the depth
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= CntMax);

endmodule

// File: rtl/sfw_dpath.sv
module sfw_dpath
  import sfw_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  sfw_strb_t        strb,
  input  logic [31:0]      wrData,
  input  logic [IDX_W-1:0] rdAddr,
  output logic [15:0]      rdData,
  output logic [15:0]      headData,
  output logic             wrPtrOdd
);

  logic [IDX_W-1:0] wrPtr, rdPtr, wrPtrNx1;
  logic [15:0]      memArr [DEPTH];

  assign wrPtrNx1 = wrPtr + 1'b1;
  assign wrPtrOdd = wrPtr[0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [15:0] entQ;
    always_ff @(posedge clk) begin
      if (strb.ldPair && wrPtr == IDX_W'(i)) begin
        entQ <= wrData[15:0];
      end else if (strb.ldPair && wrPtrNx1 == IDX_W'(i)) begin
        entQ <= wrData[31:16];
      end else if (wrPtr == IDX_W'(i)) begin
        if (strb.ldLo) entQ[7:0]  <= wrData[7:0];
        if (strb.ldHi) entQ[15:8] <= wrData[15:8];
      end
    end
    assign memArr[i] = entQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      wrPtr <= wrPtr + IDX_W'(strb.adv);
      if (strb.pop) rdPtr <= rdPtr + 1'b1;
    end
  end

  assign rdData   = memArr[rdAddr];
  assign headData = memArr[rdPtr];

  // R11: the write pointer moves by at most two slots per cycle
  a_r11_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    (IDX_W'(wrPtr - $past(wrPtr)) <= IDX_W'(2)));

  // R5: a paired store leaves the pointer even
  a_r5_pair_even: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldPair |=> !wrPtr[0]);

endmodule

// File: rtl/sample_fifo_wport.sv
module sample_fifo_wport
  import sfw_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [1:0]       wrSize,
  input  logic [31:0]      wrData,
  input  logic             popEn,
  input  logic [IDX_W-1:0] rdAddr,
  output logic [15:0]      rdData,
  output logic [15:0]      headData,
  output logic [CNT_W-1:0] fifoCount,
  output logic             fifoFull,
  output logic             fifoEmpty
);

  sfw_strb_t strb;
  logic      wrPtrOdd;

  sfw_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrSize   (wrSize),
    .popEn    (popEn),
    .wrPtrOdd (wrPtrOdd),
    .strb     (strb),
    .count    (fifoCount),
    .full     (fifoFull),
    .empty    (fifoEmpty)
  );

  sfw_dpath #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .headData (headData),
    .wrPtrOdd (wrPtrOdd)
  );

endmodule

// File: tb/sample_fifo_wport_tb.sv
module sample_fifo_wport_tb;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [1:0]  wrSize = '0;
  logic [31:0] wrData = '0;
  logic        popEn = 1'b0;
  logic [3:0]  rdAddr = '0;
  logic [15:0] rdData, headData;
  logic [4:0]  fifoCount;
  logic        fifoFull, fifoEmpty;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // scoreboard model
  int unsigned expQ[$];
  int mWp = 0;
  bit pLo = 0, pHi = 0;
  logic [7:0] loB, hiB;

  always #5 clk = ~clk;

  sample_fifo_wport u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrSize(wrSize),
    .wrData(wrData), .popEn(popEn), .rdAddr(rdAddr), .rdData(rdData),
    .headData(headData), .fifoCount(fifoCount), .fifoFull(fifoFull),
    .fifoEmpty(fifoEmpty)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkCount(input string tag);
    chk(fifoCount == 5'(expQ.size()), tag, fifoCount, expQ.size());
  endtask

  // driver: one store, optional pop in the same cycle; model updated from rules
  task automatic doWrite(input logic [1:0] sz, input logic [1:0] ad,
                         input logic [31:0] dt, input bit withPop);
    int n;
    @(negedge clk);
    n = expQ.size();
    if (withPop && n > 0) begin
      chk(headData == 16'(expQ[0]), "R10 head before pop", headData, expQ[0]);
      void'(expQ.pop_front());
    end
    if (sz == 2'd0 && !ad[1] && n < DEPTH) begin
      if (ad[0]) begin pHi = 1; hiB = dt[15:8]; end
      else       begin pLo = 1; loB = dt[7:0]; end
      if (pLo && pHi) begin
        expQ.push_back({hiB, loB}); pLo = 0; pHi = 0; mWp = (mWp + 1) % DEPTH;
      end
    end else if (sz == 2'd1 && !ad[1] && n < DEPTH) begin
      expQ.push_back(dt[15:0]); pLo = 0; pHi = 0; mWp = (mWp + 1) % DEPTH;
    end else if (sz == 2'd2 && (mWp % 2) == 0 && n <= DEPTH - 2) begin
      expQ.push_back(dt[15:0]); expQ.push_back(dt[31:16]);
      pLo = 0; pHi = 0; mWp = (mWp + 2) % DEPTH;
    end
    wrEn = 1; wrSize = sz; wrAddr = ad; wrData = dt; popEn = withPop;
    @(negedge clk);
    wrEn = 0; popEn = 0;
  endtask

  // monitor-side pop: compare head with scoreboard, then remove
  task automatic popCheck(input string tag);
    @(negedge clk);
    if (expQ.size() > 0) begin
      chk(headData == 16'(expQ[0]), tag, headData, expQ[0]);
      void'(expQ.pop_front());
    end
    popEn = 1;
    @(negedge clk);
    popEn = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1
    chk(fifoCount == 0 && fifoEmpty && !fifoFull, "R1 reset state", fifoCount, 0);

    doWrite(2'd1, 2'd0, 32'h0000_1234, 0);  chkCount("R2 half store count");
    doWrite(2'd1, 2'd2, 32'h0000_7777, 0);  chkCount("R3 misaligned half dropped");
    doWrite(2'd0, 2'd3, 32'h0000_8800, 0);  chkCount("R3 misaligned byte dropped");
    doWrite(2'd3, 2'd0, 32'h0000_9999, 0);  chkCount("R3 reserved size dropped");
    doWrite(2'd2, 2'd0, 32'hDEAD_BEEF, 0);  chkCount("R4 odd pointer word dropped");
    doWrite(2'd0, 2'd1, 32'h0000_AB00, 0);  chkCount("R8 single high lane no advance");
    doWrite(2'd0, 2'd0, 32'h0000_00CD, 0);  chkCount("R8 byte pair commits");
    doWrite(2'd2, 2'd0, 32'h5555_6666, 0);  chkCount("R5 word adds two");

    // R9 storage reads by absolute slot
    @(negedge clk);
    rdAddr = 4'd1; #1;
    chk(rdData == 16'hABCD, "R8 assembled entry via R9 read", rdData, 16'hABCD);
    rdAddr = 4'd2; #1;
    chk(rdData == 16'h6666, "R5 low half first via R9 read", rdData, 16'h6666);
    rdAddr = 4'd3; #1;
    chk(rdData == 16'h5555, "R5 high half second via R9 read", rdData, 16'h5555);
    @(negedge clk);
    chkCount("R9 read leaves count");
    chk(headData == 16'h1234, "R9 read leaves head", headData, 16'h1234);

    for (int k = 0; k < 4; k++) popCheck("R10 drain order");
    chk(fifoEmpty == 1'b1, "R10 empty after drain", fifoEmpty, 1);
    popCheck("R10 pop on empty");
    chkCount("R10 pop on empty ignored");

    // move pointers to slot 5, then build toward wrap
    doWrite(2'd1, 2'd0, 32'h0000_0101, 0);
    popCheck("R10 single pop");
    doWrite(2'd1, 2'd0, 32'h0000_0202, 0);
    for (int k = 0; k < 7; k++) doWrite(2'd2, 2'd0, {16'(k * 2 + 16'h1001), 16'(k * 2 + 16'h1000)}, 0);
    chkCount("R11 fifteen entries across wrap");
    doWrite(2'd2, 2'd0, 32'hFACE_B00C, 0);  chkCount("R7 one slot word dropped");
    doWrite(2'd0, 2'd0, 32'h0000_0034, 0);
    doWrite(2'd0, 2'd1, 32'h0000_1200, 0);
    chk(fifoFull == 1'b1, "R6 full flag", fifoFull, 1);
    doWrite(2'd1, 2'd0, 32'h0000_EEEE, 0);  chkCount("R6 half on full dropped");
    doWrite(2'd0, 2'd0, 32'h0000_00EE, 0);  chkCount("R6 byte on full dropped");
    doWrite(2'd1, 2'd0, 32'h0000_ACAC, 1);  chkCount("R6 store on full with pop");
    doWrite(2'd1, 2'd0, 32'h0000_BDBD, 1);  chkCount("R10 push with pop keeps count");
    while (expQ.size() > 0) popCheck("R11 drain across wrap");
    @(negedge clk);
    chk(fifoEmpty == 1'b1 && fifoCount == 0, "R11 empty at end", fifoCount, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule